// File: doc/BRIEF.md
# Serial ADC Channel Conversion Controller

This block runs the conversion cycle of one acquisition channel that uses an external 18-bit serial converter. A rising edge on the convert strobe starts a cycle. The block then waits for the converter's busy line to go high and then low again. After that it clocks the result out over a serial clock, data and frame-sync interface and places it in a result register, with a one-cycle valid pulse. Each wait on the busy line has a watchdog of its own. A channel whose converter is missing or not fitted therefore gives up and returns to idle, and never stalls the acquisition sequence.

Two synthetic modes replace the real conversion for bring-up. One is a counter tagged with the channel number. The other is a 32-bit maximal-length pseudo-random sequence. Both still raise the conversion-busy output for a short, fixed time and then deliver a sample with a valid pulse. Transfer logic downstream therefore sees the same completion it would see from a real conversion. The mode is taken at the convert edge.

Top module: `adc_chan_ctrl`

## Requirements
- R1: While rst_ni is low, data_o is zero and data_valid_o, conv_busy_o, adc_sclk_o and adc_sync_o are all low.
- R2: A conversion starts only on a rising edge of go_i seen while the block is idle. A strobe held high starts exactly one conversion, and a rising edge during a conversion has no effect.
- R3: After the start edge, adc_busy_i has at most 100 clock edges to be seen high. If it is not, the block returns to idle with no valid pulse and data_o unchanged.
- R4: Once adc_busy_i has been seen high, it has at most 100 clock edges to be seen low. If it stays high, the block returns to idle with no valid pulse and data_o unchanged.
- R5: On the edge where adc_busy_i is seen low, adc_sync_o goes high for one cycle. Then 18 adc_sclk_o pulses follow, each one cycle high after one cycle low. adc_sdata_i is sampled at the end of each high cycle, with the most significant bit first. data_o and data_valid_o update 37 cycles after that edge.
- R6: In counter mode (mode_i = 2'b10), the sample is {chan_i, count}, with count 14 bits wide. The count is 0 for the first such conversion after reset, rises by one for each counter-mode conversion, and wraps from 16383 to 0.
- R7: In random mode (mode_i = 2'b11), the sample is bits 17..0 of a 32-bit register. The register is seeded with 1 at reset and steps once after each random-mode conversion: it shifts right by one, and if the bit shifted out was 1 it is XORed with 32'h80200003.
- R8: In either test mode, conv_busy_o is high for exactly 4 cycles and the valid pulse comes in the next cycle. adc_sclk_o and adc_sync_o stay low, and adc_busy_i is ignored.
- R9: conv_busy_o is high from the cycle after the start edge up to the cycle before the valid pulse or the abandon. data_valid_o lasts one cycle, and data_o changes only together with it.
- R10: mode_i is sampled only on the start edge. Codes 2'b00 and 2'b01 both run a real conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Convert strobe, acted on at its rising edge |
| mode_i | input | 2 | 00/01 real, 10 counter, 11 random |
| chan_i | input | 4 | Physical channel number for the counter tag |
| adc_busy_i | input | 1 | Converter busy line |
| adc_sdata_i | input | 1 | Converter serial data |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_sync_o | output | 1 | Frame sync to the converter |
| conv_busy_o | output | 1 | Conversion in progress |
| data_o | output | 18 | Latest sample |
| data_valid_o | output | 1 | One-cycle pulse when data_o updates |

## Verification
The hardest cases to reach are the watchdog boundaries. These are a busy line that rises on the last allowed edge, one that falls on the last allowed edge of the second window, and one that rises and then never falls. The stimulus places the busy transitions on exact cycle offsets from the strobe, at 99 and 100 and past them. Counter wrap is reached with more than 16384 back-to-back counter-mode strobes, and one run changes mode_i right after the strobe.

// File: rtl/adc_chan_pkg.sv
package adc_chan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_SHIFT,
    ST_TEST
  } seq_st_e;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;
endpackage

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_chan_pkg::*;
#(
  parameter int TMO_CYC  = 100,
  parameter int TEST_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic       adc_busy_i,
  input  logic       rx_done_i,
  output logic       rx_start_o,
  output logic       done_o,
  output logic       done_test_o,
  output logic       test_rand_o,
  output logic       active_o
);
  localparam int TMR_MAX = (TMO_CYC > TEST_CYC) ? TMO_CYC : TEST_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] TMO_LAST  = TMR_W'(TMO_CYC - 1);
  localparam logic [TMR_W-1:0] TEST_LAST = TMR_W'(TEST_CYC - 1);

  seq_st_e          st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             rand_q;

  always_comb begin
    st_d        = st_q;
    tmr_d       = tmr_q + 1'b1;
    rx_start_o  = 1'b0;
    done_o      = 1'b0;
    done_test_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        tmr_d = '0;
        if (start_i) st_d = mode_i[1] ? ST_TEST : ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (adc_busy_i) begin
          st_d  = ST_WAIT_LO;
          tmr_d = '0;
        end else if (tmr_q == TMO_LAST) begin
          st_d = ST_IDLE;
        end
      end
      ST_WAIT_LO: begin
        if (!adc_busy_i) begin
          st_d       = ST_SHIFT;
          rx_start_o = 1'b1;
        end else if (tmr_q == TMO_LAST) begin
          st_d = ST_IDLE;
        end
      end
      ST_SHIFT: begin
        if (rx_done_i) begin
          st_d   = ST_IDLE;
          done_o = 1'b1;
        end
      end
      ST_TEST: begin
        if (tmr_q == TEST_LAST) begin
          st_d        = ST_IDLE;
          done_o      = 1'b1;
          done_test_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      rand_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      if (st_q == ST_IDLE && start_i) rand_q <= mode_i[0];
    end
  end

  assign test_rand_o = rand_q;
  assign active_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/adc_serial_rx.sv
module adc_serial_rx #(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  logic              active_q, sclk_q, sync_q, done_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      sync_q   <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sync_q   <= 1'b1;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
    end else if (active_q) begin
      sync_q <= 1'b0;
      done_q <= 1'b0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        // sample at the end of the high phase; converter moves data on the fall
        sclk_q <= 1'b0;
        sh_q   <= {sh_q[DATA_W-2:0], sdata_i};
        if (bit_q == BIT_LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;
  assign sync_o = sync_q;
  assign done_o = done_q;
  assign data_o = sh_q;
endmodule

// File: rtl/adc_test_pattern.sv
module adc_test_pattern
  import adc_chan_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int CHAN_W = 4,
  parameter int LFSR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              rand_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic [DATA_W-1:0] pattern_o
);
  localparam int CNT_W = DATA_W - CHAN_W;
  localparam logic [LFSR_W-1:0] TAPS = LFSR_TAPS[LFSR_W-1:0];

  logic [CNT_W-1:0]  cnt_q;
  logic [LFSR_W-1:0] lfsr_q, lfsr_nxt;

  assign lfsr_nxt = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lfsr_q <= LFSR_W'(1);
    end else if (adv_i) begin
      if (rand_i) lfsr_q <= lfsr_nxt;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign pattern_o = rand_i ? lfsr_q[DATA_W-1:0] : {chan_i, cnt_q};
endmodule

// File: rtl/adc_chan_ctrl.sv
module adc_chan_ctrl #(
  parameter int DATA_W   = 18,
  parameter int CHAN_W   = 4,
  parameter int TMO_CYC  = 100,
  parameter int TEST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [1:0]        mode_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              adc_busy_i,
  input  logic              adc_sdata_i,
  output logic              adc_sclk_o,
  output logic              adc_sync_o,
  output logic              conv_busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o
);
  logic              go_q, go_rise;
  logic              rx_start, rx_done, done, done_test, test_rand;
  logic [DATA_W-1:0] rx_data, pat;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) go_q <= 1'b0;
    else         go_q <= go_i;
  end
  assign go_rise = go_i & ~go_q;

  adc_chan_seq #(.TMO_CYC(TMO_CYC), .TEST_CYC(TEST_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (go_rise),
    .mode_i      (mode_i),
    .adc_busy_i  (adc_busy_i),
    .rx_done_i   (rx_done),
    .rx_start_o  (rx_start),
    .done_o      (done),
    .done_test_o (done_test),
    .test_rand_o (test_rand),
    .active_o    (conv_busy_o)
  );

  adc_serial_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rx_start),
    .sdata_i (adc_sdata_i),
    .sclk_o  (adc_sclk_o),
    .sync_o  (adc_sync_o),
    .done_o  (rx_done),
    .data_o  (rx_data)
  );

  adc_test_pattern #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_pat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (done_test),
    .rand_i    (test_rand),
    .chan_i    (chan_i),
    .pattern_o (pat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (done) data_q <= done_test ? pat : rx_data;
    end
  end

  assign data_o       = data_q;
  assign data_valid_o = valid_q;
endmodule

// File: rtl/adc_chan_ctrl_chk.sv
module adc_chan_ctrl_chk #(
  parameter int DATA_W  = 18,
  parameter int TMO_CYC = 100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_sclk_o,
  input logic              adc_sync_o,
  input logic              conv_busy_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_valid_o
);
  localparam int RUN_MAX = 2 * TMO_CYC + 2 * DATA_W + 8;

  int unsigned run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= 0;
    else if (conv_busy_o) run_q <= run_q + 1;
    else                  run_q <= 0;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (data_o == '0 && !data_valid_o && !conv_busy_o
                                && !adc_sclk_o && !adc_sync_o);
    end
  end

  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  a_r9_busy_then_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (!conv_busy_o && $past(conv_busy_o)));

  a_r9_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> $stable(data_o));

  a_r5_sclk_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sclk_o || adc_sync_o) |-> conv_busy_o);

  a_r5_sync_then_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_sync_o |=> (!adc_sync_o && adc_sclk_o));

  a_r3_bounded_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_MAX);
endmodule

bind adc_chan_ctrl adc_chan_ctrl_chk #(.DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .adc_sclk_o   (adc_sclk_o),
  .adc_sync_o   (adc_sync_o),
  .conv_busy_o  (conv_busy_o),
  .data_o       (data_o),
  .data_valid_o (data_valid_o)
);

// File: tb/adc_chan_ctrl_test.sv
`timescale 1ns/1ps
module adc_chan_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        go_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  chan_i = 4'd0;
  logic        adc_busy_i = 1'b0;
  logic        adc_sdata_i = 1'b0;
  logic        adc_sclk_o, adc_sync_o, conv_busy_o, data_valid_o;
  logic [17:0] data_o;

  adc_chan_ctrl uut (.*);

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // expectation state
  int          at_q[$];
  logic [17:0] d_q[$];
  int          bfrom = -1000, bto = -1000, sstart = -1000;
  logic [17:0] exp_d = '0;
  string       cur_req = "R1";
  int          vectors = 0, miscompares = 0;
  bit          finished = 0;

  // reference models of the pattern sources
  logic [13:0] ref_cnt = '0;
  logic [31:0] ref_lfsr = 32'd1;

  // converter model: loads on sync, shifts on falling sclk, MSB first
  logic [17:0] adc_val = '0, adc_sh = '0;
  logic        prev_sclk = 1'b0;
  always @(negedge clk_i) begin
    if (adc_sync_o) adc_sh = adc_val;
    else if (prev_sclk && !adc_sclk_o) adc_sh = adc_sh << 1;
    prev_sclk   = adc_sclk_o;
    adc_sdata_i = adc_sh[17];
  end

  always @(negedge clk_i) begin
    logic        ev, ev_b, ev_sy, ev_sc;
    logic [17:0] ev_d;
    if (!rst_ni) begin
      ev = 0; ev_b = 0; ev_sy = 0; ev_sc = 0; ev_d = '0;
    end else begin
      ev = (at_q.size() > 0) && (at_q[0] == cyc);
      if (ev) begin
        exp_d = d_q[0];
        void'(at_q.pop_front());
        void'(d_q.pop_front());
      end
      ev_d  = exp_d;
      ev_b  = (cyc >= bfrom) && (cyc < bto);
      ev_sy = (cyc == sstart);
      ev_sc = (cyc > sstart) && (cyc < sstart + 36) && (((cyc - sstart) % 2) == 1);
    end
    vectors++;
    if (data_valid_o !== ev || data_o !== ev_d || conv_busy_o !== ev_b ||
        adc_sync_o !== ev_sy || adc_sclk_o !== ev_sc) begin
      miscompares++;
      $display("FAIL %s cyc=%0d act v=%b d=%h busy=%b sync=%b sclk=%b exp v=%b d=%h busy=%b sync=%b sclk=%b",
               cur_req, cyc, data_valid_o, data_o, conv_busy_o, adc_sync_o, adc_sclk_o,
               ev, ev_d, ev_b, ev_sy, ev_sc);
    end
    if (cyc > 190000 && !finished) begin
      miscompares++;
      finished = 1;
      $display("FAIL watchdog cyc=%0d act running exp done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // a: offset of busy rise (<0: never); b: edges after rise seen until fall (<0: stuck)
  task automatic conv_real(input int a, input int b, input logic [17:0] val,
                           input logic [1:0] md, input int go_len, input int rep_at);
    int g, h, s, fin;
    g = cyc + 1;
    h = g + a + 1;
    s = h + b;
    bfrom  = g;
    sstart = -1000;
    if (a < 0) begin
      bto = g + 100; fin = g + 103;
    end else if (b < 0) begin
      bto = h + 100; fin = h + 102;
    end else begin
      bto = s + 37; sstart = s; fin = s + 39;
      at_q.push_back(s + 37); d_q.push_back(val);
      adc_val = val;
    end
    fin = imax(fin, g + go_len + 2);
    if (rep_at > 0) fin = imax(fin, g + rep_at + 4);
    mode_i = md;
    go_i   = 1'b1;
    fork
      begin
        automatic int gl = g + go_len;
        wait_to(gl);
        go_i = 1'b0;
      end
    join_none
    if (rep_at > 0) begin
      fork
        begin
          automatic int r = g + rep_at;
          wait_to(r);
          go_i = 1'b1;
          wait_to(r + 2);
          go_i = 1'b0;
        end
      join_none
    end
    if (a >= 0) begin
      wait_to(g + a);
      adc_busy_i = 1'b1;
      if (b < 0) begin
        wait_to(h + 101);
      end else begin
        wait_to(s - 1);
      end
      adc_busy_i = 1'b0;
    end
    wait_to(fin);
  endtask

  task automatic conv_test(input logic [1:0] md, input bit flip_mode);
    int g;
    logic [17:0] v;
    g = cyc + 1;
    if (md[0]) begin
      v = ref_lfsr[17:0];
      ref_lfsr = (ref_lfsr >> 1) ^ (ref_lfsr[0] ? 32'h8020_0003 : 32'h0);
    end else begin
      v = {chan_i, ref_cnt};
      ref_cnt = ref_cnt + 1'b1;
    end
    bfrom = g; bto = g + 4; sstart = -1000;
    at_q.push_back(g + 4); d_q.push_back(v);
    mode_i = md;
    go_i   = 1'b1;
    wait_to(g);
    go_i = 1'b0;
    if (flip_mode) mode_i = ~md;
    wait_to(g + 4);
    mode_i = md;
  endtask

  initial begin
    cur_req = "R1";
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    cur_req = "R5";
    conv_real(3, 5, 18'h2A5C3, 2'b00, 0, 0);
    conv_real(0, 1, 18'h3FFFF, 2'b00, 1, 0);
    conv_real(6, 2, 18'h20001, 2'b00, 0, 0);
    cur_req = "R10";
    conv_real(2, 4, 18'h1B3E9, 2'b01, 0, 0);
    cur_req = "R2";
    conv_real(2, 3, 18'h0F0F0, 2'b00, 80, 0);
    conv_real(20, 4, 18'h15555, 2'b00, 2, 6);
    cur_req = "R3";
    conv_real(-1, 0, 18'h00000, 2'b00, 0, 0);
    conv_real(99, 3, 18'h12345, 2'b00, 0, 0);
    cur_req = "R4";
    conv_real(4, -1, 18'h00000, 2'b00, 0, 0);
    conv_real(4, 100, 18'h0ABCD, 2'b00, 0, 0);

    cur_req = "R6";
    chan_i = 4'd5;
    for (int i = 0; i < 3; i++) conv_test(2'b10, 0);
    chan_i = 4'd11;
    cur_req = "R10";
    conv_test(2'b10, 1);
    cur_req = "R7";
    for (int i = 0; i < 6; i++) conv_test(2'b11, 0);
    cur_req = "R8";
    adc_busy_i = 1'b1;
    conv_test(2'b11, 0);
    conv_test(2'b10, 0);
    adc_busy_i = 1'b0;
    cur_req = "R9";
    conv_real(1, 2, 18'h00F00, 2'b00, 0, 0);
    cur_req = "R6";
    chan_i = 4'd9;
    for (int i = 0; i < 16390; i++) conv_test(2'b10, 0);
    cur_req = "R7";
    conv_test(2'b11, 0);
    repeat (4) @(negedge clk_i);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule